// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures an intermediate-frequency signal by counting its rising edges over a fixed time window. Software or a control sequencer raises a start input. The block then waits for a settling interval and opens the counting window. When the window closes, it freezes the result and raises a done flag. Dropping start at any time returns the block to idle and clears the result. Start therefore acts both as the trigger and as a synchronous clear.

A two-bit gate code picks the window length. The settling interval depends on the chosen code. All timing comes from a one-cycle millisecond tick input, so both intervals are counted in whole ticks. The signal input is asynchronous to the clock and passes through a two-flop synchroniser before its edges are counted. While the inhibit input is high, the block is held stopped in idle.

Top module: `if_gate_counter`

## Requirements
- R1: After reset, and on the clock edge after start is sampled low, count, done and overflow are all 0.
- R2: A measurement begins on the first clock edge that samples start high in idle. The gate code is captured at that edge, and later changes to the code have no effect on that measurement.
- R3: The settling wait lasts 4 ticks for gate codes 0 and 1, and 8 ticks for codes 2 and 3. Rising edges on the signal input during the wait are not counted.
- R4: The window lasts 4, 8, 32 or 64 ticks for gate code values 0, 1, 2 and 3. Done rises on the edge that samples the last window tick, and not earlier.
- R5: During the window, count rises by one for each rising edge of the signal input, after the two-flop synchroniser.
- R6: Once done is high, count and done hold while start stays high and inhibit stays low. Further input edges are ignored.
- R7: Count saturates at 2^CNT_W-1. An edge that arrives while count is at that value sets overflow, and overflow is 0 otherwise.
- R8: While inhibit is high, the block sits in idle with count, done and overflow at 0. When inhibit falls with start still high, a new measurement begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | 1 runs a measurement, 0 clears the block |
| gate_sel | input | 2 | Window length code |
| inhibit | input | 1 | Holds the block stopped in idle |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| if_in | input | 1 | Asynchronous signal to be counted |
| count | output | CNT_W | Edge count |
| done | output | 1 | Result valid |
| overflow | output | 1 | Count saturated and another edge arrived |

## Verification
Every gate code is run with burst sizes of zero, one, a few and several dozen pulses. This separates a correct window length from an off-by-one in the tick counters. Bursts placed in the settling phase and after the window closes show whether the wait is counted or whether the frozen result is disturbed. A small counter width is used so that bursts of exactly the maximum and one past it can separate saturation from wraparound. Changing the gate code in mid-run and pulsing inhibit in mid-window show whether the captured code and the stop path behave as required.

// File: rtl/if_gate_counter.sv
module if_gate_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       gate_sel,
  input  logic             inhibit,
  input  logic             ms_tick,
  input  logic             if_in,
  output logic [CNT_W-1:0] count,
  output logic             done,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

  typedef enum logic [1:0] {IDLE, WAIT, GATE, HOLD} st_t;
  st_t        st;
  logic [1:0] sel_q;
  logic [6:0] tcnt, span;
  logic [2:0] sh;
  logic       rise, last;

  assign rise = sh[1] & ~sh[2];
  assign span = (st == WAIT) ? (sel_q[1] ? 7'd8 : 7'd4) :
                (sel_q == 2'd0) ? 7'd4 : (sel_q == 2'd1) ? 7'd8 :
                (sel_q == 2'd2) ? 7'd32 : 7'd64;
  assign last = ms_tick && (tcnt == span - 7'd1);
  assign done = (st == HOLD);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], if_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; sel_q <= '0; tcnt <= '0; count <= '0; overflow <= 1'b0;
    end else if (!start || inhibit) begin
      st <= IDLE; tcnt <= '0; count <= '0; overflow <= 1'b0;
    end else begin
      case (st)
        IDLE: begin
          sel_q <= gate_sel;
          tcnt  <= '0;
          st    <= WAIT;
        end
        WAIT: if (ms_tick) begin
          tcnt <= last ? 7'd0 : tcnt + 7'd1;
          if (last) st <= GATE;
        end
        GATE: begin
          if (rise) begin
            if (count == MAXC) overflow <= 1'b1;
            else               count <= count + 1'b1;
          end
          if (ms_tick) begin
            tcnt <= last ? 7'd0 : tcnt + 7'd1;
            if (last) st <= HOLD;
          end
        end
        default: ;
      endcase
    end
  end

  // R1
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (count == '0 && !done && !overflow));
  // R8
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> (st == IDLE && count == '0 && !done));
  // R6
  done_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start && !inhibit) |=> (done && $stable(count)));
  // R7
  sat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> count == MAXC);
  // R3
  gate_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != GATE && start && !inhibit) |=> $stable(count));
endmodule

// File: tb/sim_if_gate_counter.sv
module sim_if_gate_counter;
  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;
  logic clk = 0, rst_n = 0, start = 0, inhibit = 0, ms_tick = 0, if_in = 0;
  logic [1:0] gate_sel = 0;
  logic [W-1:0] count;
  logic done, overflow;
  int checks = 0, errors = 0;
  bit finished = 0;

  if_gate_counter #(.CNT_W(W)) u0 (.clk, .rst_n, .start, .gate_sel, .inhibit,
    .ms_tick, .if_in, .count, .done, .overflow);

  always #2.5 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic tick();
    @(posedge clk); #1 ms_tick = 1;
    @(posedge clk); #1 ms_tick = 0;
  endtask

  task automatic pulses(int n);
    repeat (n) begin
      @(posedge clk); #1 if_in = 1;
      @(posedge clk); #1 if_in = 0;
    end
    cyc(8);
  endtask

  function automatic int glen(int c);
    return c == 0 ? 4 : c == 1 ? 8 : c == 2 ? 32 : 64;
  endfunction

  task automatic run(int code, int k, int pre, int post);
    int wl = code[1] ? 8 : 4;
    int exp = k > MAXV ? MAXV : k;
    @(posedge clk); #1 gate_sel = code[1:0]; start = 1;
    cyc(2);
    pulses(pre);
    for (int i = 0; i < wl; i++) tick();
    cyc(4);
    check("R3 count after wait", count, 0);
    check("R3 done after wait", done, 0);
    pulses(k);
    for (int i = 0; i < glen(code) - 1; i++) tick();
    cyc(2);
    check("R4 done before last tick", done, 0);
    tick();
    cyc(1);
    check("R4 done after last tick", done, 1);
    check("R5 count", count, exp);
    check("R7 overflow", overflow, k > MAXV);
    pulses(post);
    check("R6 count frozen", count, exp);
    check("R6 done held", done, 1);
    @(posedge clk); #1 start = 0;
    cyc(2);
    check("R1 cleared count", count, 0);
    check("R1 cleared done", done, 0);
    check("R1 cleared overflow", overflow, 0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    check("R1 reset count", count, 0);
    check("R1 reset done", done, 0);
    check("R1 reset overflow", overflow, 0);

    for (int c = 0; c < 4; c++) begin
      run(c, 0, 3, 2);
      run(c, 1, 0, 0);
      run(c, 5, 7, 4);
      run(c, 37, 1, 9);
    end
    run(3, MAXV, 0, 0);
    run(3, MAXV + 1, 0, 0);
    run(3, MAXV + 40, 0, 3);

    // R2: the code is captured at start, so a later change does not alter the timing
    @(posedge clk); #1 gate_sel = 0; start = 1;
    cyc(2);
    gate_sel = 3;
    for (int i = 0; i < 4; i++) tick();
    pulses(6);
    for (int i = 0; i < 3; i++) tick();
    cyc(2);
    check("R2 done before captured window end", done, 0);
    tick();
    cyc(1);
    check("R2 done at captured window end", done, 1);
    check("R2 count", count, 6);
    @(posedge clk); #1 start = 0;
    cyc(2);

    // R8: inhibit in mid-window
    @(posedge clk); #1 gate_sel = 1; start = 1;
    cyc(2);
    for (int i = 0; i < 4; i++) tick();
    pulses(9);
    check("R8 count before inhibit", count, 9);
    @(posedge clk); #1 inhibit = 1;
    cyc(2);
    check("R8 count under inhibit", count, 0);
    pulses(5);
    for (int i = 0; i < 12; i++) tick();
    check("R8 count held", count, 0);
    check("R8 done held", done, 0);
    @(posedge clk); #1 inhibit = 0;
    cyc(2);
    for (int i = 0; i < 4; i++) tick();
    pulses(11);
    for (int i = 0; i < 8; i++) tick();
    cyc(1);
    check("R8 restart done", done, 1);
    check("R8 restart count", count, 11);
    @(posedge clk); #1 start = 0;
    cyc(2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule